// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block gathers 32 numbered interrupt requests for a single processor. A pulse on request line N sets pending bit N. The pending flag is then combined with a per-source enable mask and one global enable bit. The controller drives two signals to the processor. The interrupt line is a registered level. It is high only while the global enable is on and at least one pending source is also unmasked. The wake pulse ends a halt state. It fires when an arriving request hits an unmasked source, whatever the global enable holds.

Software reaches the pending set, the mask and the global enable through a 16-bit port. The two 32-bit registers are split into low and high halves. Pending bits are cleared by writing ones to them. Every change of state is reflected on the interrupt line one clock later. This covers requests, acknowledges, mask writes and global-enable writes alike.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A one-cycle pulse on request line N sets pending bit N. Lines 0 to 15 land in the low pending half, read with select 0. Lines 16 to 31 land in the high pending half, read with select 1. The bit reads back set from the cycle after the pulse.
- R2: In the cycle after a request arrives on a line whose mask bit is set, the wake output is high for exactly one cycle, whether or not the global enable is on. A request on a masked-off line gives no wake pulse.
- R3: A write to select 0 clears each low pending bit where the written data holds a 1, and a write to select 1 does the same for the high pending half. Data bits that are 0 leave the pending bits unchanged.
- R4: When a request and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R5: The interrupt output is a registered level. It is high exactly when the global enable is on and the AND of mask and pending is nonzero. It follows each change of that condition one cycle later.
- R6: Writing the mask re-evaluates the interrupt. With the global enable on, unmasking a pending source raises the output one cycle later, and masking the last such source drops it.
- R7: A write to select 4 sets the global enable. A nonzero bit 0 raises the interrupt one cycle later if any mask and pending bits overlap. Writing 0 drops the interrupt.
- R8: Only bit 0 of the global enable is stored. A write to select 4 with bit 0 clear turns the enable off, even if other bits are set. Bits 15 to 1 of the select-4 readback are always 0.
- R9: After the synchronous active-low reset, pending, mask and global enable are all 0, and both outputs are low.
- R10: Select 2 writes mask bits 15 to 0 and select 3 writes mask bits 31 to 16. Both read back through the same selects, and a write to one half leaves the other unchanged.
- R11: Writes with selects 5, 6 or 7 change no state, and reads with those selects return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 32 | Request pulses, one line per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Register select for the combinational readback |
| rd_data_o | output | 16 | Readback data |
| irq_o | output | 1 | Interrupt level to the processor |
| wake_o | output | 1 | One-cycle halt-exit pulse |

## Verification
The bench targets the split between the two outputs. It sends requests on unmasked lines while the global enable is off. A design that tied wake to the global enable would stay asleep, and one that let the interrupt ignore it would fire. It hits a pending bit with a request and an acknowledge in the same cycle, which catches a clear that wins over the set. It writes the global enable with only upper bits set, which catches a design that tests the whole word instead of bit 0. It also toggles mask and enable with no new request, so a design that only re-evaluates on request arrival leaves the interrupt stuck. A long pseudo-random run mixes all of these against an arithmetic model of the registers.

// File: rtl/irq_mask_pkg.sv
// Shared constants for the masked interrupt controller.
// Assumes a 3-bit register select on both the write and read ports.
package irq_mask_pkg;
    localparam logic [2:0] SEL_PEND_LO = 3'd0;
    localparam logic [2:0] SEL_PEND_HI = 3'd1;
    localparam logic [2:0] SEL_MASK_LO = 3'd2;
    localparam logic [2:0] SEL_MASK_HI = 3'd3;
    localparam logic [2:0] SEL_MASTER  = 3'd4;
    localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending bank: latches request pulses and clears bits on write-one acknowledge.
// Assumes each acknowledge strobe is already decoded to one half; set wins over clear.
module irq_pend_bank #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned NUM_SRC = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [1:0]         ack_we_i,
    input  logic [HALF_W-1:0]  ack_data_i,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] pend_nxt
);
    logic [NUM_SRC-1:0] clr_vec;

    // Place the acknowledge data in the half picked by its strobe.
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign clr_vec[h*HALF_W +: HALF_W] = ack_we_i[h] ? ack_data_i : '0;
        end
    endgenerate

    // Next pending set: clear acknowledged bits, then OR in new requests.
    always_comb begin
        pend_nxt = (pend_q & ~clr_vec) | req_i;
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i))); // R4

    AST_ACK_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we_i[0] && req_i[HALF_W-1:0] == '0) |=>
        ((pend_q[HALF_W-1:0] & $past(ack_data_i)) == '0)); // R3
endmodule

// File: rtl/irq_mask_regs.sv
// Enable storage: the 32-bit source mask in two halves plus the one-bit global enable.
// Assumes write strobes are already decoded; only data bit 0 reaches the global enable.
module irq_mask_regs #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned NUM_SRC = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mask_we_i,
    input  logic               master_we_i,
    input  logic [HALF_W-1:0]  wr_data_i,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] mask_nxt,
    output logic               master_q,
    output logic               master_nxt
);
    // Next mask value: each half replaced only by its own strobe.
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign mask_nxt[h*HALF_W +: HALF_W] =
                mask_we_i[h] ? wr_data_i : mask_q[h*HALF_W +: HALF_W];
        end
    endgenerate

    // Next global enable keeps bit 0 of the written data only.
    always_comb begin
        master_nxt = master_we_i ? wr_data_i[0] : master_q;
    end

    // Enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            master_q <= 1'b0;
        end else begin
            mask_q   <= mask_nxt;
            master_q <= master_nxt;
        end
    end

    AST_MASK_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i[0] |=> $stable(mask_q[HALF_W-1:0])); // R10
endmodule

// File: rtl/irq_signal_gen.sv
// Output stage: registered interrupt level from next-state values and a wake pulse.
// Assumes next-state inputs reflect this cycle's requests and writes.
module irq_signal_gen #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] mask_nxt,
    input  logic [NUM_SRC-1:0] pend_nxt,
    input  logic               master_nxt,
    output logic               irq_o,
    output logic               wake_o
);
    logic hit_any;
    logic wake_hit;

    // Decide interrupt and wake conditions.
    always_comb begin
        hit_any  = |(mask_nxt & pend_nxt);
        wake_hit = |(req_i & mask_q);
    end

    // Register both outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= master_nxt & hit_any;
            wake_o <= wake_hit;
        end
    end

    AST_WAKE_IGNORES_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_i & mask_q)) |=> wake_o); // R2
endmodule

// File: rtl/irq_mask_ctrl.sv
// Two-level masked interrupt controller top: write decode, readback and submodule wiring.
// Assumes one register access per cycle through a 16-bit port with a 3-bit select.
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned NUM_SRC = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [HALF_W-1:0]  wr_data_i,
    input  logic [2:0]         rd_sel_i,
    output logic [HALF_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               wake_o
);
    logic [1:0]         ack_we;
    logic [1:0]         mask_we;
    logic               master_we;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_nxt;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_nxt;
    logic               master_q;
    logic               master_nxt;

    // Decode the write select into per-register strobes.
    always_comb begin
        ack_we[0]  = wr_en_i && (wr_sel_i == SEL_PEND_LO);
        ack_we[1]  = wr_en_i && (wr_sel_i == SEL_PEND_HI);
        mask_we[0] = wr_en_i && (wr_sel_i == SEL_MASK_LO);
        mask_we[1] = wr_en_i && (wr_sel_i == SEL_MASK_HI);
        master_we  = wr_en_i && (wr_sel_i == SEL_MASTER);
    end

    irq_pend_bank #(.HALF_W(HALF_W)) pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .ack_we_i   (ack_we),
        .ack_data_i (wr_data_i),
        .pend_q     (pend_q),
        .pend_nxt   (pend_nxt)
    );

    irq_mask_regs #(.HALF_W(HALF_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we_i   (mask_we),
        .master_we_i (master_we),
        .wr_data_i   (wr_data_i),
        .mask_q      (mask_q),
        .mask_nxt    (mask_nxt),
        .master_q    (master_q),
        .master_nxt  (master_nxt)
    );

    irq_signal_gen #(.NUM_SRC(NUM_SRC)) sig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .mask_q     (mask_q),
        .mask_nxt   (mask_nxt),
        .pend_nxt   (pend_nxt),
        .master_nxt (master_nxt),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    // Combinational readback; unused selects return zero.
    always_comb begin
        case (rd_sel_i)
            SEL_PEND_LO: rd_data_o = pend_q[HALF_W-1:0];
            SEL_PEND_HI: rd_data_o = pend_q[NUM_SRC-1:HALF_W];
            SEL_MASK_LO: rd_data_o = mask_q[HALF_W-1:0];
            SEL_MASK_HI: rd_data_o = mask_q[NUM_SRC-1:HALF_W];
            SEL_MASTER:  rd_data_o = {{(HALF_W-1){1'b0}}, master_q};
            default:     rd_data_o = '0;
        endcase
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (master_q && (|(mask_q & pend_q)))); // R5

    AST_MASTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_i == SEL_MASTER) |-> (rd_data_o[HALF_W-1:1] == '0)); // R8

    AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_i > SEL_MASTER) |-> (rd_data_o == '0)); // R11
endmodule

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic        wake;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    logic [31:0] m_pend = '0;
    logic [31:0] m_mask = '0;
    logic        m_ime  = 1'b0;
    logic [31:0] lfsr   = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    irq_mask_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .wake_o    (wake)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Read every select and compare against the model (R11 spare select 5 reads 0).
    task automatic check_regs(input string tag);
        logic [15:0] exp_rd [8];
        exp_rd[0] = m_pend[15:0];
        exp_rd[1] = m_pend[31:16];
        exp_rd[2] = m_mask[15:0];
        exp_rd[3] = m_mask[31:16];
        exp_rd[4] = {15'd0, m_ime};
        exp_rd[5] = '0;
        exp_rd[6] = '0;
        exp_rd[7] = '0;
        for (int s = 0; s < 8; s++) begin
            rd_sel = 3'(s);
            #1;
            chk(tag, $sformatf("read sel %0d", s), {16'd0, rd_data}, {16'd0, exp_rd[s]});
        end
    endtask

    // One clock of stimulus, model update and full comparison.
    task automatic step(input logic [31:0] r, input logic we, input logic [2:0] s,
                        input logic [15:0] d, input string tag);
        logic [31:0] clr;
        logic exp_wake;
        logic exp_irq;
        req = r; wr_en = we; wr_sel = s; wr_data = d;
        @(posedge clk);
        exp_wake = |(r & m_mask);
        clr = '0;
        if (we && s == 3'd0) clr[15:0]  = d;
        if (we && s == 3'd1) clr[31:16] = d;
        m_pend = (m_pend & ~clr) | r;
        if (we && s == 3'd2) m_mask[15:0]  = d;
        if (we && s == 3'd3) m_mask[31:16] = d;
        if (we && s == 3'd4) m_ime = d[0];
        exp_irq = m_ime & (|(m_mask & m_pend));
        @(negedge clk);
        req = '0; wr_en = 1'b0;
        chk(tag, "irq", {31'd0, irq}, {31'd0, exp_irq});
        chk(tag, "wake", {31'd0, wake}, {31'd0, exp_wake});
        check_regs(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9", "irq after reset", {31'd0, irq}, 32'd0);
        chk("R9", "wake after reset", {31'd0, wake}, 32'd0);
        check_regs("R9");

        // R1: every line lands in its half, then is acknowledged
        for (int i = 0; i < 32; i++) begin
            step(32'd1 << i, 1'b0, 3'd0, 16'd0, "R1");
            step('0, 1'b1, (i < 16) ? 3'd0 : 3'd1, 16'd1 << (i % 16), "R3");
        end

        // R10 then R2: alternating mask, wake only on unmasked lines, global enable off
        step('0, 1'b1, 3'd2, 16'hAAAA, "R10");
        step('0, 1'b1, 3'd3, 16'h5555, "R10");
        for (int i = 0; i < 32; i++) begin
            step(32'd1 << i, 1'b0, 3'd0, 16'd0, "R2");
            step('0, 1'b1, (i < 16) ? 3'd0 : 3'd1, 16'hFFFF, "R3");
        end
        step('0, 1'b1, 3'd2, 16'h0000, "R10");
        step('0, 1'b1, 3'd3, 16'h0000, "R10");

        // R3: partial acknowledge patterns
        step(32'hFFFF_FFFF, 1'b0, 3'd0, 16'd0, "R1");
        step('0, 1'b1, 3'd0, 16'h00F0, "R3");
        step('0, 1'b1, 3'd1, 16'h0000, "R3");
        step('0, 1'b1, 3'd1, 16'hC003, "R3");
        step('0, 1'b1, 3'd0, 16'hFFFF, "R3");
        step('0, 1'b1, 3'd1, 16'hFFFF, "R3");

        // R4: set and clear of the same bit in one cycle
        step(32'h0000_0008, 1'b1, 3'd0, 16'h0008, "R4");
        step(32'h0001_0000, 1'b1, 3'd1, 16'h0001, "R4");

        // R6, R7, R8: re-evaluation on mask and global-enable writes
        step('0, 1'b1, 3'd4, 16'h0001, "R7");
        step('0, 1'b1, 3'd2, 16'h0008, "R6");
        step('0, 1'b1, 3'd2, 16'h0000, "R6");
        step('0, 1'b1, 3'd3, 16'h0001, "R6");
        step('0, 1'b1, 3'd4, 16'h0000, "R7");
        step('0, 1'b1, 3'd4, 16'hFFFE, "R8");
        step('0, 1'b1, 3'd4, 16'h0003, "R8");
        step('0, 1'b1, 3'd1, 16'h0001, "R5");
        step('0, 1'b1, 3'd0, 16'h0008, "R5");

        // R11: spare selects change nothing
        step('0, 1'b1, 3'd5, 16'hFFFF, "R11");
        step('0, 1'b1, 3'd6, 16'hFFFF, "R11");
        step('0, 1'b1, 3'd7, 16'hFFFF, "R11");

        // R5: pseudo-random mix of requests and writes against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr;
            step((a[3:0] == 4'd0) ? (a & b & {b[15:0], b[31:16]}) : 32'd0,
                 b[0] | b[1], a[7:5], b[31:16], "R5");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule